// File: doc/BRIEF.md
# Wakeup Event Lookup Controller

The controller keeps a table of sixteen programmable wakeup entries, written and read over a simple word-addressed register bus. Each entry picks one trigger line: a bit of one of two GPIO ports, or one of the peripheral interrupt lines. A rising edge on that line marks the entry pending. A pending entry raises a wake request toward the master it targets: the main CPU, the radio controller or the sensor controller. It also raises the power-domain and crystal requests that the entry asks for.

Software reads the full pending vector, or one of three per-master views of it. It clears an entry by writing the entry's index to an acknowledge register, and marks an entry pending by writing its index to a set register. The set register also serves entries that have no hardware source.

Each entry's pending state is a two-state machine. `ENT_IDLE` moves to `ENT_PEND` on the *arm* transition, which is a hardware edge or a software set. `ENT_PEND` moves back to `ENT_IDLE` on the *release* transition, which is an acknowledge with no set in the same cycle. Otherwise each state holds. All requests are combinational functions of the pending states and the entry table.

Top module: `wk_lookup_ctrl`

## Requirements
- R1: After reset every entry register, the pending vector and every wake and domain request output read as zero.
- R2: Entry n sits at byte address 4*n (n = 0..15). Its fields are: trigger bank in bits [1:0], trigger index in bits [8:2], crystal request bit 9, timer-domain bit 10, peripheral-domain bit 11, communication-domain bit 12, and target in bits [14:13]. A read returns the stored fields, with bits [31:15] zero.
- R3: Bank 0 selects bit `index` of `gpio_a`, and bank 1 selects bit `index` of `gpio_b`. An index at or beyond the port width selects a constant low. A rising edge on the selected line makes the entry pending at that clock edge. A line held high does not re-arm an entry after it is acknowledged.
- R4: Banks 2 and 3 select `periph_irq` using only index bits [3:0]. Peripheral index 15 has no hardware source.
- R5: An entry whose target is 0 never becomes pending from hardware.
- R6: Writing to address 0x80 clears the entry whose index is in write-data bits [4:0]. An index of 16 or more has no effect.
- R7: Writing to address 0x94 sets the entry whose index is in bits [4:0]. An index of 16 or more has no effect. When a set and an acknowledge hit one entry in the same cycle, the entry stays pending.
- R8: Address 0x84 reads the 16-bit pending vector. Address 0x88 reads the pending entries with target 3 (sensor controller), 0x8C those with target 1 (main CPU), and 0x90 those with target 2 (radio controller). Bits [31:16] read zero, and reads of 0x80 and 0x94 return zero.
- R9: `wake_sensor`, `wake_cpu` and `wake_radio` are each the OR of the matching view, valid in the cycle the pending state changes.
- R10: `req_xtal`, `req_tmr`, `req_per` and `req_com` are each the OR of that enable bit over all pending entries. An entry with target 3 counts as having its communication bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Register write strobe for this cycle |
| bus_addr | input | 8 | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| gpio_a | input | GPIO_W | GPIO port selected by bank 0 |
| gpio_b | input | GPIO_W | GPIO port selected by bank 1 |
| periph_irq | input | PERIPH_W | Peripheral interrupt lines selected by banks 2 and 3 |
| wake_cpu | output | 1 | Wake request to the main CPU |
| wake_radio | output | 1 | Wake request to the radio controller |
| wake_sensor | output | 1 | Wake request to the sensor controller |
| req_xtal | output | 1 | Crystal start request |
| req_tmr | output | 1 | Timer domain enable request |
| req_per | output | 1 | Peripheral domain enable request |
| req_com | output | 1 | Communication domain enable request |

## Verification
Triggers are driven as single edges on each GPIO port, a peripheral line reached through an index with its high bits set, an all-lines burst, and lines held high across an acknowledge. Together these separate edge detection from level detection, the bank decode and the index truncation. Entries with target 0 and with the sourceless index 15 are hit by real edges and then armed by software, which separates the hardware arming path from the software one. An acknowledge is placed in the same cycle as a rising edge, and out-of-range indices are written to both command registers, to show that set wins and that bad indices are dropped. Enable patterns spread over several pending entries show the OR merge and the forced communication request for the sensor target.

// File: rtl/wk_pkg.sv
package wk_pkg;

    localparam int BUS_AW   = 8;
    localparam int IDX_BITS = 7;
    localparam int CMD_W    = 5;

    localparam logic [BUS_AW-1:0] ADDR_ACK  = 8'h80;
    localparam logic [BUS_AW-1:0] ADDR_PEND = 8'h84;
    localparam logic [BUS_AW-1:0] ADDR_VSEN = 8'h88;
    localparam logic [BUS_AW-1:0] ADDR_VCPU = 8'h8C;
    localparam logic [BUS_AW-1:0] ADDR_VRAD = 8'h90;
    localparam logic [BUS_AW-1:0] ADDR_SET  = 8'h94;

    typedef enum logic [1:0] {
        TGT_OFF    = 2'd0,
        TGT_CPU    = 2'd1,
        TGT_RADIO  = 2'd2,
        TGT_SENSOR = 2'd3
    } tgt_e;

    typedef enum logic {
        ENT_IDLE = 1'b0,
        ENT_PEND = 1'b1
    } ent_state_e;

    // packed MSB first: target[14:13] com[12] per[11] tmr[10] xtal[9] idx[8:2] bank[1:0]
    typedef struct packed {
        tgt_e                target;
        logic                en_com;
        logic                en_per;
        logic                en_tmr;
        logic                en_xtal;
        logic [IDX_BITS-1:0] idx;
        logic [1:0]          bank;
    } ent_cfg_t;

    localparam int CFG_W = $bits(ent_cfg_t);

endpackage

// File: rtl/wk_cfg_bank.sv
module wk_cfg_bank
    import wk_pkg::*;
#(
    parameter int N_ENTRY = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      bus_we,
    input  logic [BUS_AW-1:0]         bus_addr,
    input  logic [31:0]               bus_wdata,
    output ent_cfg_t [N_ENTRY-1:0]    cfg,
    output logic [N_ENTRY-1:0]        sw_set,
    output logic [N_ENTRY-1:0]        sw_clr
);

    localparam int WORD_W = BUS_AW - 2;

    logic [WORD_W-1:0] word;
    logic [CMD_W-1:0]  cmd_idx;
    logic              cmd_ok;
    logic              hit_set;
    logic              hit_ack;

    assign word    = bus_addr[BUS_AW-1:2];
    assign cmd_idx = bus_wdata[CMD_W-1:0];
    assign cmd_ok  = cmd_idx < CMD_W'(N_ENTRY);
    assign hit_set = bus_we && (bus_addr == ADDR_SET) && cmd_ok;
    assign hit_ack = bus_we && (bus_addr == ADDR_ACK) && cmd_ok;

    for (genvar e = 0; e < N_ENTRY; e++) begin : g_ent
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cfg[e] <= '0;
            end else if (bus_we && (word == WORD_W'(e))) begin
                cfg[e] <= ent_cfg_t'(bus_wdata[CFG_W-1:0]);
            end
        end

        assign sw_set[e] = hit_set && (cmd_idx == CMD_W'(e));
        assign sw_clr[e] = hit_ack && (cmd_idx == CMD_W'(e));
    end

endmodule

// File: rtl/wk_trig_match.sv
module wk_trig_match
    import wk_pkg::*;
#(
    parameter int GPIO_W   = 32,
    parameter int PERIPH_W = 15
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          bank,
    input  logic [IDX_BITS-1:0] idx,
    input  logic                armed,
    input  logic [GPIO_W-1:0]   gpio_a,
    input  logic [GPIO_W-1:0]   gpio_b,
    input  logic [PERIPH_W-1:0] periph_irq,
    output logic                hw_rise
);

    localparam int GSPAN = 1 << IDX_BITS;
    localparam int PSPAN = 16;

    logic [GSPAN-1:0] ga_x;
    logic [GSPAN-1:0] gb_x;
    logic [PSPAN-1:0] px;
    logic             sel;
    logic             sel_q;

    // zero extension gives out-of-range indices a constant low source
    assign ga_x = GSPAN'(gpio_a);
    assign gb_x = GSPAN'(gpio_b);
    assign px   = PSPAN'(periph_irq);

    always_comb begin
        unique case (bank)
            2'd0:    sel = ga_x[idx];
            2'd1:    sel = gb_x[idx];
            default: sel = px[idx[3:0]];
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q <= 1'b0;
        end else begin
            sel_q <= sel;
        end
    end

    assign hw_rise = armed && sel && !sel_q;

endmodule

// File: rtl/wk_pend_fsm.sv
module wk_pend_fsm
    import wk_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hw_set,
    input  logic sw_set,
    input  logic sw_clr,
    output logic pend
);

    ent_state_e state_q;
    ent_state_e state_d;
    logic       arm;

    assign arm = hw_set || sw_set;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ENT_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ENT_IDLE: if (arm) state_d = ENT_PEND;
            ENT_PEND: if (sw_clr && !arm) state_d = ENT_IDLE;
            default:  state_d = ENT_IDLE;
        endcase
    end

    always_comb begin
        unique case (state_q)
            ENT_PEND: pend = 1'b1;
            default:  pend = 1'b0;
        endcase
    end

endmodule

// File: rtl/wk_out_merge.sv
module wk_out_merge
    import wk_pkg::*;
#(
    parameter int N_ENTRY = 16
) (
    input  ent_cfg_t [N_ENTRY-1:0] cfg,
    input  logic [N_ENTRY-1:0]     pend,
    output logic [N_ENTRY-1:0]     view_cpu,
    output logic [N_ENTRY-1:0]     view_radio,
    output logic [N_ENTRY-1:0]     view_sensor,
    output logic                   wake_cpu,
    output logic                   wake_radio,
    output logic                   wake_sensor,
    output logic                   req_xtal,
    output logic                   req_tmr,
    output logic                   req_per,
    output logic                   req_com
);

    logic [N_ENTRY-1:0] v_xtal;
    logic [N_ENTRY-1:0] v_tmr;
    logic [N_ENTRY-1:0] v_per;
    logic [N_ENTRY-1:0] v_com;

    for (genvar e = 0; e < N_ENTRY; e++) begin : g_ent
        assign view_cpu[e]    = pend[e] && (cfg[e].target == TGT_CPU);
        assign view_radio[e]  = pend[e] && (cfg[e].target == TGT_RADIO);
        assign view_sensor[e] = pend[e] && (cfg[e].target == TGT_SENSOR);
        assign v_xtal[e]      = pend[e] && cfg[e].en_xtal;
        assign v_tmr[e]       = pend[e] && cfg[e].en_tmr;
        assign v_per[e]       = pend[e] && cfg[e].en_per;
        assign v_com[e]       = pend[e] && (cfg[e].en_com || (cfg[e].target == TGT_SENSOR));
    end

    assign wake_cpu    = |view_cpu;
    assign wake_radio  = |view_radio;
    assign wake_sensor = |view_sensor;
    assign req_xtal    = |v_xtal;
    assign req_tmr     = |v_tmr;
    assign req_per     = |v_per;
    assign req_com     = |v_com;

endmodule

// File: rtl/wk_lookup_ctrl.sv
module wk_lookup_ctrl
    import wk_pkg::*;
#(
    parameter int N_ENTRY  = 16,
    parameter int GPIO_W   = 32,
    parameter int PERIPH_W = 15
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_we,
    input  logic [7:0]          bus_addr,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    input  logic [GPIO_W-1:0]   gpio_a,
    input  logic [GPIO_W-1:0]   gpio_b,
    input  logic [PERIPH_W-1:0] periph_irq,
    output logic                wake_cpu,
    output logic                wake_radio,
    output logic                wake_sensor,
    output logic                req_xtal,
    output logic                req_tmr,
    output logic                req_per,
    output logic                req_com
);

    localparam int ENT_W = (N_ENTRY > 1) ? $clog2(N_ENTRY) : 1;
    localparam int WORD_W = BUS_AW - 2;

    ent_cfg_t [N_ENTRY-1:0] cfg;
    logic [N_ENTRY-1:0]     sw_set;
    logic [N_ENTRY-1:0]     sw_clr;
    logic [N_ENTRY-1:0]     hw_rise;
    logic [N_ENTRY-1:0]     pend_q;
    logic [N_ENTRY-1:0]     view_cpu;
    logic [N_ENTRY-1:0]     view_radio;
    logic [N_ENTRY-1:0]     view_sensor;

    wk_cfg_bank #(.N_ENTRY(N_ENTRY)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .cfg       (cfg),
        .sw_set    (sw_set),
        .sw_clr    (sw_clr)
    );

    for (genvar e = 0; e < N_ENTRY; e++) begin : g_ent
        wk_trig_match #(.GPIO_W(GPIO_W), .PERIPH_W(PERIPH_W)) u_trig (
            .clk        (clk),
            .rst_n      (rst_n),
            .bank       (cfg[e].bank),
            .idx        (cfg[e].idx),
            .armed      (cfg[e].target != TGT_OFF),
            .gpio_a     (gpio_a),
            .gpio_b     (gpio_b),
            .periph_irq (periph_irq),
            .hw_rise    (hw_rise[e])
        );

        wk_pend_fsm u_pend (
            .clk    (clk),
            .rst_n  (rst_n),
            .hw_set (hw_rise[e]),
            .sw_set (sw_set[e]),
            .sw_clr (sw_clr[e]),
            .pend   (pend_q[e])
        );
    end

    wk_out_merge #(.N_ENTRY(N_ENTRY)) u_merge (
        .cfg         (cfg),
        .pend        (pend_q),
        .view_cpu    (view_cpu),
        .view_radio  (view_radio),
        .view_sensor (view_sensor),
        .wake_cpu    (wake_cpu),
        .wake_radio  (wake_radio),
        .wake_sensor (wake_sensor),
        .req_xtal    (req_xtal),
        .req_tmr     (req_tmr),
        .req_per     (req_per),
        .req_com     (req_com)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_addr[BUS_AW-1:2] < WORD_W'(N_ENTRY)) begin
            bus_rdata = {{(32-CFG_W){1'b0}}, cfg[bus_addr[ENT_W+1:2]]};
        end else begin
            case (bus_addr)
                ADDR_PEND: bus_rdata = 32'(pend_q);
                ADDR_VSEN: bus_rdata = 32'(view_sensor);
                ADDR_VCPU: bus_rdata = 32'(view_cpu);
                ADDR_VRAD: bus_rdata = 32'(view_radio);
                default:   bus_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/wk_lookup_ctrl_chk.sv
module wk_lookup_ctrl_chk #(
    parameter int N_ENTRY = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               bus_we,
    input logic [7:0]         bus_addr,
    input logic [31:0]        bus_wdata,
    input logic [31:0]        bus_rdata,
    input logic [N_ENTRY-1:0] pend,
    input logic [N_ENTRY-1:0] hw_rise,
    input logic               wake_cpu,
    input logic               wake_radio,
    input logic               wake_sensor,
    input logic               req_xtal,
    input logic               req_tmr,
    input logic               req_per,
    input logic               req_com
);

    logic [N_ENTRY-1:0] set_cmd;
    logic [N_ENTRY-1:0] ack_cmd;
    logic [N_ENTRY-1:0] ack_only;

    always_comb begin
        set_cmd = '0;
        ack_cmd = '0;
        for (int e = 0; e < N_ENTRY; e++) begin
            if (bus_we && bus_addr == 8'h94 && {27'd0, bus_wdata[4:0]} == e) set_cmd[e] = 1'b1;
            if (bus_we && bus_addr == 8'h80 && {27'd0, bus_wdata[4:0]} == e) ack_cmd[e] = 1'b1;
        end
    end

    assign ack_only = ack_cmd & ~hw_rise;

    // R7: a software set is visible on the next cycle
    p_set_lands_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_cmd) |=> ((pend & $past(set_cmd)) == $past(set_cmd)));

    // R6: an acknowledge with no competing edge clears the entry
    p_ack_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (|ack_only) |=> ((pend & $past(ack_only)) == '0));

    // R3: a pending bit only rises after an edge or a set command
    p_pend_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (((pend & ~$past(pend)) & ~$past(hw_rise | set_cmd)) == '0));

    // R9: with nothing pending every request is low
    p_quiet_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pend == '0) |-> !(wake_cpu || wake_radio || wake_sensor ||
                           req_xtal || req_tmr || req_per || req_com));

    // R8: the pending register has no bits above the entry count
    p_pend_upper_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == 8'h84) |-> ((bus_rdata >> N_ENTRY) == '0));

endmodule

bind wk_lookup_ctrl wk_lookup_ctrl_chk #(.N_ENTRY(N_ENTRY)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_we      (bus_we),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .pend        (pend_q),
    .hw_rise     (hw_rise),
    .wake_cpu    (wake_cpu),
    .wake_radio  (wake_radio),
    .wake_sensor (wake_sensor),
    .req_xtal    (req_xtal),
    .req_tmr     (req_tmr),
    .req_per     (req_per),
    .req_com     (req_com)
);

// File: tb/wk_lookup_ctrl_test.sv
`timescale 1ns/1ps
module wk_lookup_ctrl_test;

    localparam int GW = 32;
    localparam int PW = 15;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_we = 1'b0;
    logic [7:0]    bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [GW-1:0] gpio_a = '0;
    logic [GW-1:0] gpio_b = '0;
    logic [PW-1:0] periph_irq = '0;
    logic wake_cpu, wake_radio, wake_sensor;
    logic req_xtal, req_tmr, req_per, req_com;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    wk_lookup_ctrl #(.N_ENTRY(16), .GPIO_W(GW), .PERIPH_W(PW)) uut (
        .clk, .rst_n, .bus_we, .bus_addr, .bus_wdata, .bus_rdata,
        .gpio_a, .gpio_b, .periph_irq,
        .wake_cpu, .wake_radio, .wake_sensor,
        .req_xtal, .req_tmr, .req_per, .req_com
    );

    function automatic logic [31:0] mk(input int bank, input int idx, input bit xt,
                                       input bit tm, input bit pe, input bit co, input int tgt);
        logic [31:0] v;
        v = '0;
        v[1:0]   = bank[1:0];
        v[8:2]   = idx[6:0];
        v[9]     = xt;
        v[10]    = tm;
        v[11]    = pe;
        v[12]    = co;
        v[14:13] = tgt[1:0];
        return v;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
        bus_addr = '0;
    endtask

    task automatic step;
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic [31:0] outs;
        return {25'd0, wake_cpu, wake_radio, wake_sensor, req_xtal, req_tmr, req_per, req_com};
    endfunction

    task automatic t_reset;
        logic [31:0] d;
        rd(8'h00, d); check("R1 entry0", d, 0);
        rd(8'h3C, d); check("R1 entry15", d, 0);
        rd(8'h84, d); check("R1 pending", d, 0);
        check("R1 outputs", outs(), 0);
    endtask

    task automatic t_regs;
        logic [31:0] d;
        wr(8'h0C, 32'hFFFF_FFFF);
        rd(8'h0C, d); check("R2 upper bits zero", d, 32'h0000_7FFF);
        wr(8'h0C, 32'hABCD_0000 | mk(1, 7'h2A, 1, 0, 1, 0, 2));
        rd(8'h0C, d); check("R2 field readback", d, mk(1, 7'h2A, 1, 0, 1, 0, 2));
        rd(8'h84, d); check("R2 no pending from config", d, 0);
    endtask

    task automatic t_gpio;
        logic [31:0] d;
        wr(8'h00, mk(0, 5, 1, 0, 0, 0, 1));
        wr(8'h04, mk(1, 31, 0, 1, 0, 0, 2));
        gpio_a[5] = 1'b1; step();
        rd(8'h84, d); check("R3 port a edge", d, 32'h1);
        rd(8'h8C, d); check("R8 cpu view", d, 32'h1);
        check("R9 wake_cpu", {31'd0, wake_cpu}, 1);
        check("R10 xtal only", {29'd0, req_xtal, req_tmr, req_per}, 3'b100);
        gpio_b[31] = 1'b1; step();
        rd(8'h84, d); check("R3 port b edge", d, 32'h3);
        rd(8'h90, d); check("R8 radio view", d, 32'h2);
        check("R9 wake_radio", {31'd0, wake_radio}, 1);
        check("R10 xtal and tmr", {29'd0, req_xtal, req_tmr, req_per}, 3'b110);
        wr(8'h80, 32'd0);
        rd(8'h84, d); check("R3 held level does not re-arm", d, 32'h2);
        wr(8'h80, 32'd1);
        rd(8'h84, d); check("R6 ack entry1", d, 0);
        gpio_a = '0; gpio_b = '0; step();
    endtask

    task automatic t_periph;
        logic [31:0] d;
        wr(8'h08, mk(2, 7'h73, 0, 0, 1, 0, 3));
        periph_irq[3] = 1'b1; step();
        rd(8'h84, d); check("R4 low index bits select irq3", d, 32'h4);
        rd(8'h88, d); check("R8 sensor view", d, 32'h4);
        check("R9 wake_sensor only", {29'd0, wake_cpu, wake_radio, wake_sensor}, 3'b001);
        check("R10 sensor forces com", {30'd0, req_per, req_com}, 2'b11);
        wr(8'h80, 32'd2);
        periph_irq = '0; step();
        wr(8'h10, mk(3, 7'h0F, 0, 0, 0, 0, 1));
        periph_irq = '1; step();
        rd(8'h84, d); check("R4 index 15 has no source", d, 32'h4);
        periph_irq = '0; wr(8'h80, 32'd2);
        wr(8'h94, 32'd4);
        rd(8'h84, d); check("R4 index 15 via software set", d, 32'h10);
        wr(8'h80, 32'd4);
        wr(8'h14, mk(3, 14, 0, 0, 0, 0, 2));
        periph_irq[14] = 1'b1; step();
        rd(8'h84, d); check("R4 bank 3 irq14", d, 32'h20);
        wr(8'h80, 32'd5);
        periph_irq = '0; step();
    endtask

    task automatic t_disabled;
        logic [31:0] d;
        wr(8'h18, mk(0, 7, 0, 0, 1, 0, 0));
        gpio_a[7] = 1'b1; step();
        rd(8'h84, d); check("R5 target 0 ignores edge", d, 0);
        gpio_a[7] = 1'b0; step();
        wr(8'h94, 32'd6);
        rd(8'h84, d); check("R7 set disabled entry", d, 32'h40);
        rd(8'h88, d); check("R8 no view for target 0", d, 0);
        check("R9 R10 wakes low, per high", outs(), 32'b0000010);
        wr(8'h80, 32'd22);
        rd(8'h84, d); check("R6 ack index 22 ignored", d, 32'h40);
        wr(8'h94, 32'd20);
        rd(8'h84, d); check("R7 set index 20 ignored", d, 32'h40);
        wr(8'h80, 32'd6);
        rd(8'h84, d); check("R6 ack entry6", d, 0);
        rd(8'h80, d); check("R8 ack register reads zero", d, 0);
    endtask

    task automatic t_collision;
        logic [31:0] d;
        wr(8'h1C, mk(0, 9, 0, 0, 0, 0, 1));
        wr(8'h94, 32'd7);
        rd(8'h84, d); check("R7 set entry7", d, 32'h80);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = 8'h80; bus_wdata = 32'd7; gpio_a[9] = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
        rd(8'h84, d); check("R7 edge beats ack", d, 32'h80);
        wr(8'h80, 32'd7);
        rd(8'h84, d); check("R6 ack after collision", d, 0);
        gpio_a[9] = 1'b0; step();
    endtask

    task automatic t_enables;
        wr(8'h20, mk(0, 0, 1, 0, 0, 0, 2));
        wr(8'h24, mk(0, 0, 0, 1, 0, 1, 1));
        wr(8'h94, 32'd8);
        check("R10 entry8 enables", outs(), 32'b0101000);
        wr(8'h94, 32'd9);
        check("R10 merged enables", outs(), 32'b1101101);
        wr(8'h80, 32'd8);
        check("R10 after ack8", outs(), 32'b1000101);
        wr(8'h80, 32'd9);
        check("R9 all quiet", outs(), 0);
    endtask

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        step();
        t_reset();
        t_regs();
        t_gpio();
        t_periph();
        t_disabled();
        t_collision();
        t_enables();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule